// File: doc/BRIEF.md
# Retriggerable One-Shot PWM Timer

This block is a counter-based pulse generator that stays parked after it is enabled and only begins a PWM cycle when a trigger arrives. A trigger is either a chosen edge on an asynchronous external input or a one-clock software strobe. Each trigger zeroes the counter, drives the PWM output to its active level and flips a second toggle output. A trigger that arrives while a cycle is in progress restarts the cycle from zero at once.

The period and the active width come from two compare registers. Software may write them at any time. Each value is held in a shadow buffer, and the buffer only takes the new value when the counter wraps at the end of a period, so a cycle in progress never changes shape. The counter only advances on clocks where the count-enable tick is high, so a prescaler outside the block sets the count rate. Two single-clock interrupt pulses mark the end of a period and the point where the width is reached.

Top module: `oneshot_pwm_timer`

## Requirements
- R1: With the enable high and no trigger seen since enable, the counter does not run: PWM output stays low and no interrupt pulse occurs.
- R2: A one-clock software strobe with a tick in the same clock starts a cycle. At the next sample the PWM output is high, and the toggle output has flipped from its previous value.
- R3: A trigger during a running cycle restarts the count from zero. The next period pulse arrives exactly (period value + 1) ticks after the clock that took the trigger.
- R4: A period ends when the count equals the period buffer. The counter then returns to zero and the period pulse is high for one clock. Consecutive period pulses are (period value + 1) ticks apart.
- R5: The PWM output is high for exactly (width value) ticks from each restart of the count, goes low when the count reaches the width buffer, and the width pulse is high once in that clock.
- R6: A compare value written during a cycle has no effect on the current period. It takes effect starting with the period that follows the next wrap.
- R7: Every trigger forces the PWM output high, whatever its state, and inverts the toggle output.
- R8: The external trigger passes through a two-flop synchroniser. `edge_sel_i` selects the edge that counts: 2'b00 rising, 2'b01 falling, 2'b10 both, 2'b11 none. An edge that is not selected leaves the toggle output unchanged.
- R9: On clocks where the tick is low, the counter, the outputs and the interrupts hold their state.
- R10: A low enable parks the counter, drives both outputs low and discards any pending trigger. A software strobe while disabled has no effect after enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable tick; the counter steps only when high |
| en_i | input | 1 | Timer enable |
| ext_trig_i | input | 1 | Asynchronous external trigger input |
| edge_sel_i | input | 2 | External edge select (00 rise, 01 fall, 10 both, 11 none) |
| sw_trig_i | input | 1 | Software trigger strobe |
| period_wr_i | input | 1 | Write strobe for the period register |
| period_wdata_i | input | CNT_W | Period value (period is value + 1 ticks) |
| width_wr_i | input | 1 | Write strobe for the width register |
| width_wdata_i | input | CNT_W | Active width in ticks |
| pwm_o | output | 1 | PWM output, active high |
| tog_o | output | 1 | Output that inverts on every trigger |
| period_irq_o | output | 1 | One-clock pulse at period wrap |
| width_irq_o | output | 1 | One-clock pulse when the count reaches the width |

## Verification
The bench uses the default 16-bit counter and a two-stage synchroniser. It programs small compare values (periods of 10 and 6 ticks, widths of 3 and 2), so that period spacing, width, reload at wrap and mid-cycle restart can all be measured to the exact tick within a few dozen clocks. Because the block is at full width, the parked all-ones state and the wrap compare run on the real 16-bit datapath. Tick gating is tested by holding the tick low across a whole period.

// File: rtl/opwm_pkg.sv
package opwm_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/opwm_trig_sync.sv
module opwm_trig_sync
  import opwm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ext_i,
  input  edge_sel_e sel_i,
  output logic      edge_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] chain_q;
  logic         prev_q;
  logic         synced;
  logic         rise, fall;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= ext_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign synced = chain_q[MSB];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;

  assign rise = synced & ~prev_q;
  assign fall = ~synced & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

  p_edge_after_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (synced != prev_q));
endmodule

// File: rtl/opwm_compare_shadow.sv
module opwm_compare_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running_i,
  input  logic             reload_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_wdata_i,
  input  logic             wid_wr_i,
  input  logic [CNT_W-1:0] wid_wdata_i,
  output logic [CNT_W-1:0] per_buf_o,
  output logic [CNT_W-1:0] wid_buf_o
);
  logic [CNT_W-1:0] per_q, wid_q;
  logic             take;

  assign take = !running_i || reload_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q     <= '0;
      wid_q     <= '0;
      per_buf_o <= '0;
      wid_buf_o <= '0;
    end else begin
      if (per_wr_i) per_q <= per_wdata_i;
      if (wid_wr_i) wid_q <= wid_wdata_i;
      if (take) begin
        per_buf_o <= per_q;
        wid_buf_o <= wid_q;
      end
    end
  end

  p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running_i && !reload_i) |=> ($stable(per_buf_o) && $stable(wid_buf_o)));
endmodule

// File: rtl/opwm_counter_core.sv
module opwm_counter_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] per_buf_i,
  input  logic [CNT_W-1:0] wid_buf_i,
  output logic             running_o,
  output logic             reload_o,
  output logic             pwm_o,
  output logic             tog_o,
  output logic             period_irq_o,
  output logic             width_irq_o
);
  localparam logic [CNT_W-1:0] PARK = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             pend_q, pend_any, apply, step, wrap;

  assign pend_any = pend_q | trig_i;
  assign apply    = en_i & tick_i & pend_any;
  assign step     = en_i & tick_i & running_o & ~apply;
  assign wrap     = step & (cnt_q == per_buf_i);
  assign reload_o = wrap;
  assign cnt_inc  = cnt_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= PARK;
      running_o    <= 1'b0;
      pend_q       <= 1'b0;
      pwm_o        <= 1'b0;
      tog_o        <= 1'b0;
      period_irq_o <= 1'b0;
      width_irq_o  <= 1'b0;
    end else begin
      period_irq_o <= 1'b0;
      width_irq_o  <= 1'b0;
      if (!en_i) begin
        cnt_q     <= PARK;
        running_o <= 1'b0;
        pend_q    <= 1'b0;
        pwm_o     <= 1'b0;
        tog_o     <= 1'b0;
      end else begin
        pend_q <= pend_any & ~tick_i;
        if (apply) begin
          cnt_q     <= '0;
          running_o <= 1'b1;
          pwm_o     <= 1'b1;
          tog_o     <= ~tog_o;
        end else if (wrap) begin
          cnt_q        <= '0;
          pwm_o        <= 1'b1;
          period_irq_o <= 1'b1;
        end else if (step) begin
          cnt_q <= cnt_inc;
          if (cnt_inc == wid_buf_i) begin
            pwm_o       <= 1'b0;
            width_irq_o <= 1'b1;
          end
        end
      end
    end
  end

  p_parked_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> (cnt_q == PARK && !period_irq_o && !width_irq_o));
  p_trig_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && trig_i) |=> pwm_o);
  p_trig_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && trig_i) |=> (tog_o != $past(tog_o)));
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq_o |-> (cnt_q == '0 && pwm_o));
  p_width_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    width_irq_o |-> (!pwm_o && cnt_q == wid_buf_i));
  p_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> ($stable(cnt_q) && $stable(pwm_o) && !period_irq_o));
  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!pwm_o && !tog_o && !running_o));
endmodule

// File: rtl/oneshot_pwm_timer.sv
module oneshot_pwm_timer
  import opwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             ext_trig_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             sw_trig_i,
  input  logic             period_wr_i,
  input  logic [CNT_W-1:0] period_wdata_i,
  input  logic             width_wr_i,
  input  logic [CNT_W-1:0] width_wdata_i,
  output logic             pwm_o,
  output logic             tog_o,
  output logic             period_irq_o,
  output logic             width_irq_o
);
  logic             ext_edge, trig, running, reload;
  logic [CNT_W-1:0] per_buf, wid_buf;
  edge_sel_e        sel;

  assign sel  = edge_sel_e'(edge_sel_i);
  assign trig = en_i & (ext_edge | sw_trig_i);

  opwm_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .ext_i (ext_trig_i),
    .sel_i (sel),
    .edge_o(ext_edge)
  );

  opwm_compare_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .running_i  (running),
    .reload_i   (reload),
    .per_wr_i   (period_wr_i),
    .per_wdata_i(period_wdata_i),
    .wid_wr_i   (width_wr_i),
    .wid_wdata_i(width_wdata_i),
    .per_buf_o  (per_buf),
    .wid_buf_o  (wid_buf)
  );

  opwm_counter_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .tick_i      (tick_i),
    .trig_i      (trig),
    .per_buf_i   (per_buf),
    .wid_buf_i   (wid_buf),
    .running_o   (running),
    .reload_o    (reload),
    .pwm_o       (pwm_o),
    .tog_o       (tog_o),
    .period_irq_o(period_irq_o),
    .width_irq_o (width_irq_o)
  );

  p_irq_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(period_irq_o && width_irq_o));
endmodule

// File: tb/tb_oneshot_pwm_timer.sv
module tb_oneshot_pwm_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_i = 1'b1;
  logic         en_i = 1'b0;
  logic         ext_trig_i = 1'b0;
  logic [1:0]   edge_sel_i = 2'b00;
  logic         sw_trig_i = 1'b0;
  logic         period_wr_i = 1'b0;
  logic [W-1:0] period_wdata_i = '0;
  logic         width_wr_i = 1'b0;
  logic [W-1:0] width_wdata_i = '0;
  logic         pwm_o, tog_o, period_irq_o, width_irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pirq_n = 0;
  int wirq_n = 0;

  oneshot_pwm_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (period_irq_o) pirq_n <= pirq_n + 1;
    if (width_irq_o)  wirq_n <= wirq_n + 1;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sw_pulse();
    sw_trig_i = 1'b1;
    @(negedge clk);
    sw_trig_i = 1'b0;
  endtask

  task automatic write_regs(input int per, input int wid);
    period_wr_i = 1'b1; period_wdata_i = W'(per);
    width_wr_i  = 1'b1; width_wdata_i  = W'(wid);
    @(negedge clk);
    period_wr_i = 1'b0; width_wr_i = 1'b0;
  endtask

  task automatic wait_pirq(output int at);
    at = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (period_irq_o) begin at = cyc; break; end
    end
  endtask

  task automatic high_run(output int n);
    n = 0;
    while (pwm_o && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_idle();
    chk(pwm_o == 0 && tog_o == 0, "R10 reset outputs", {pwm_o, tog_o}, 0);
    write_regs(9, 3);
    en_i = 1'b1;
    begin
      int p0 = pirq_n;
      int w0 = wirq_n;
      idle(30);
      chk(pwm_o == 0, "R1 idle pwm", pwm_o, 0);
      chk(pirq_n == p0 && wirq_n == w0, "R1 idle irq", pirq_n + wirq_n - p0 - w0, 0);
    end
  endtask

  task automatic t_basic();
    int a, b, n, w0;
    sw_pulse();
    chk(pwm_o == 1, "R2 pwm after start", pwm_o, 1);
    chk(tog_o == 1, "R2 toggle after start", tog_o, 1);
    wait_pirq(a);
    w0 = wirq_n;
    high_run(n);
    chk(n == 3, "R5 active width", n, 3);
    wait_pirq(b);
    chk(b - a == 10, "R4 period spacing", b - a, 10);
    chk(wirq_n - w0 == 1, "R5 width pulse count", wirq_n - w0, 1);
  endtask

  task automatic t_reload();
    int a, b, c, n;
    write_regs(5, 2);
    a = cyc - 1;
    wait_pirq(b);
    chk(b - a == 10, "R6 old period kept", b - a, 10);
    wait_pirq(c);
    chk(c - b == 6, "R6 new period applied", c - b, 6);
    high_run(n);
    chk(n == 2, "R6 new width applied", n, 2);
  endtask

  task automatic t_retrigger();
    int a, t1;
    logic tg;
    wait_pirq(a);
    idle(4);
    chk(pwm_o == 0, "R3 pwm low before retrigger", pwm_o, 0);
    tg = tog_o;
    sw_pulse();
    t1 = cyc;
    chk(pwm_o == 1, "R7 forced high on retrigger", pwm_o, 1);
    chk(tog_o == !tg, "R7 toggle inverts", tog_o, !tg);
    wait_pirq(a);
    chk(a - t1 == 6, "R3 restart spacing", a - t1, 6);
  endtask

  task automatic t_tick_hold();
    int p0, a;
    logic pv;
    tick_i = 1'b0;
    @(negedge clk);
    pv = pwm_o;
    p0 = pirq_n;
    idle(20);
    chk(pwm_o == pv, "R9 pwm held", pwm_o, pv);
    chk(pirq_n == p0, "R9 no period pulse", pirq_n - p0, 0);
    tick_i = 1'b1;
    wait_pirq(a);
    chk(a > 0, "R9 resumes", a, 1);
  endtask

  task automatic t_ext_edges();
    logic tg;
    edge_sel_i = 2'b00;
    tg = tog_o; ext_trig_i = 1'b1; idle(6);
    chk(tog_o == !tg, "R8 rising selected", tog_o, !tg);
    tg = tog_o; ext_trig_i = 1'b0; idle(6);
    chk(tog_o == tg, "R8 falling ignored", tog_o, tg);
    edge_sel_i = 2'b01;
    tg = tog_o; ext_trig_i = 1'b1; idle(6);
    chk(tog_o == tg, "R8 rising ignored", tog_o, tg);
    tg = tog_o; ext_trig_i = 1'b0; idle(6);
    chk(tog_o == !tg, "R8 falling selected", tog_o, !tg);
    edge_sel_i = 2'b10;
    tg = tog_o; ext_trig_i = 1'b1; idle(6);
    ext_trig_i = 1'b0; idle(6);
    chk(tog_o == tg, "R8 both edges two flips", tog_o, tg);
    edge_sel_i = 2'b11;
    tg = tog_o; ext_trig_i = 1'b1; idle(6);
    chk(tog_o == tg, "R8 none selected", tog_o, tg);
    ext_trig_i = 1'b0; idle(6);
    edge_sel_i = 2'b00;
  endtask

  task automatic t_disable();
    int p0;
    en_i = 1'b0;
    @(negedge clk);
    chk(pwm_o == 0 && tog_o == 0, "R10 outputs low", {pwm_o, tog_o}, 0);
    sw_pulse();
    idle(3);
    en_i = 1'b1;
    p0 = pirq_n;
    idle(20);
    chk(pwm_o == 0 && pirq_n == p0, "R10 pending discarded", pwm_o, 0);
    sw_pulse();
    chk(pwm_o == 1 && tog_o == 1, "R2 restart after enable", {pwm_o, tog_o}, 3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset_idle();
    t_basic();
    t_reload();
    t_retrigger();
    t_tick_hold();
    t_ext_edges();
    t_disable();
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule